// File: doc/BRIEF.md
# Shift-Register Random Byte and CRC16 Engine

This block holds one 16-bit linear feedback shift register and offers it to a processor through a small byte-wide register bus. The same register does three jobs. Writes to the low data register seed it. Reads of the low data register advance it to produce pseudo-random bytes. Writes to the high data register fold a byte into a running CRC16. A 2-bit mode field sets how the register responds. It can step on reads, take one step on command, let only writes change it, or freeze it completely.

Each step uses the feedback mask 0x8005, which is x^16 + x^15 + x^2 + 1. The incoming bit is XORed with bit 15. The register shifts left, and if that XOR result is 1 the mask is applied. There is no bit reflection and no output XOR. Random steps use an input bit of zero. A CRC byte enters most significant bit first, and all eight steps are done in one cycle, so the bus can write a byte every clock. Reads return the register contents as they were before any update in that same cycle.

Top module: `lfsr_crc_engine`

## Requirements
- R1: Reset (rst_n low) clears the shift register to 0x0000 and the mode field to 00.
- R2: rd_data is combinational on rd_addr and shows the values held before the next clock edge. Address 0 gives bits 7:0 of the register, address 1 gives bits 15:8, address 2 gives the mode in bits 1:0 with zeros above, and address 3 gives 0x00.
- R3: A write to address 0 moves bits 7:0 of the register into bits 15:8 and loads wr_data into bits 7:0. Two writes therefore load a full 16-bit seed, the first byte ending up high.
- R4: A write to address 1 applies eight steps in one clock edge, taking wr_data most significant bit first. The step function is the one given above, with mask 0x8005. Writes may arrive back to back. After seeding 0xFFFF, the bytes 0x03, 0x41, 0x42, 0x43 leave 0xB4BC.
- R5: In mode 00, a read (rd_en) of address 0 advances the register by 13 zero-input steps at the next edge.
- R6: Writing 01 to address 2 (mode field in wr_data[1:0]) makes the register take exactly one zero-input step at the edge after the write. The mode field then reads 00.
- R7: In mode 11 the register holds its value. Data writes and low-register reads have no effect on it, but address 2 can still be written.
- R8: In mode 10, reads of address 0 do not step the register, while writes to addresses 0 and 1 still take effect.
- R9: Updates follow a fixed priority: a high write first, then a low write, then a pending single step, then a read step. A data write in the cycle where the single step is pending cancels that step, and the mode field still clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 low data, 1 high data, 2 mode |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe (only a read of address 0 has a side effect) |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read byte, combinational |

## Verification
rd_data is due in the same cycle as rd_addr and shows the pre-edge state. The bench therefore drives each vector just after a falling edge and compares rd_data one time unit later, before the rising edge applies the update. Seed writes, CRC writes and read steps show up one rising edge after their strobe. A single-step command shows up two edges after the mode write: one edge loads the mode, the next takes the step and clears the mode. The bench's reference model advances only at rising edges, so each of these delays is counted by construction. Every cycle's rd_data is compared with the model. Fixed checks for the CRC vector, the 13-step read and the single step then compare against constants as well.

// File: rtl/lfsr_crc_pkg.sv
package lfsr_crc_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_RAND   = 2'b00,
    MODE_STEP   = 2'b01,
    MODE_MANUAL = 2'b10,
    MODE_OFF    = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ADR_LOW  = 2'd0,
    ADR_HIGH = 2'd1,
    ADR_MODE = 2'd2,
    ADR_NONE = 2'd3
  } addr_e;

  // One shift with data input; feedback applied through the mask.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s,
                                                  input logic din,
                                                  input logic [LFSR_W-1:0] poly);
    logic fb;
    fb = s[LFSR_W-1] ^ din;
    return {s[LFSR_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

  // n zero-input shifts, unrolled in hardware when n is constant.
  function automatic logic [LFSR_W-1:0] lfsr_advance(input logic [LFSR_W-1:0] s,
                                                     input int unsigned n,
                                                     input logic [LFSR_W-1:0] poly);
    logic [LFSR_W-1:0] t;
    t = s;
    for (int unsigned i = 0; i < n; i++) t = lfsr_step(t, 1'b0, poly);
    return t;
  endfunction

  // Fold one byte in, most significant bit first.
  function automatic logic [LFSR_W-1:0] crc_byte(input logic [LFSR_W-1:0] s,
                                                 input logic [BYTE_W-1:0] b,
                                                 input logic [LFSR_W-1:0] poly);
    logic [LFSR_W-1:0] t;
    t = s;
    for (int i = BYTE_W - 1; i >= 0; i--) t = lfsr_step(t, b[i], poly);
    return t;
  endfunction
endpackage

// File: rtl/lfsr_bus_decode.sv
module lfsr_bus_decode
  import lfsr_crc_pkg::*;
(
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic       rd_en,
  input  logic [1:0] rd_addr,
  output logic       crc_wr,
  output logic       seed_wr,
  output logic       mode_wr,
  output logic       low_rd
);
  always_comb begin
    crc_wr  = wr_en && (wr_addr == ADR_HIGH);
    seed_wr = wr_en && (wr_addr == ADR_LOW);
    mode_wr = wr_en && (wr_addr == ADR_MODE);
    low_rd  = rd_en && (rd_addr == ADR_LOW);
  end
endmodule

// File: rtl/lfsr_mode_reg.sv
module lfsr_mode_reg
  import lfsr_crc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_wval,
  output mode_e             mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               mode <= MODE_RAND;
    else if (mode_wr)         mode <= mode_e'(mode_wval);
    else if (mode == MODE_STEP) mode <= MODE_RAND;
  end

  // R6: a pending single step is consumed after one cycle
  p_step_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STEP && !mode_wr) |=> (mode == MODE_RAND))
    else $error("single-step mode did not clear");

  // R6: a mode write is taken as written
  p_mode_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (mode == $past(mode_wval)))
    else $error("mode write not loaded");
endmodule

// File: rtl/lfsr_state.sv
module lfsr_state
  import lfsr_crc_pkg::*;
#(
  parameter logic [LFSR_W-1:0] POLY       = 16'h8005,
  parameter int unsigned       RAND_STEPS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  logic              crc_wr,
  input  logic              seed_wr,
  input  logic              low_rd,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [LFSR_W-1:0] state
);
  localparam int unsigned HALF = LFSR_W - BYTE_W;

  // Named update events, one of which (or none) fires per cycle.
  logic ev_hold, ev_crc, ev_seed, ev_single, ev_rand;
  logic [LFSR_W-1:0] state_nx;

  always_comb begin
    ev_hold   = (mode == MODE_OFF);
    ev_crc    = !ev_hold && crc_wr;
    ev_seed   = !ev_hold && !crc_wr && seed_wr;
    ev_single = !ev_hold && !crc_wr && !seed_wr && (mode == MODE_STEP);
    ev_rand   = !ev_hold && !crc_wr && !seed_wr && (mode == MODE_RAND) && low_rd;
  end

  always_comb begin
    state_nx = state;
    unique case (1'b1)
      ev_crc:    state_nx = crc_byte(state, wbyte, POLY);
      ev_seed:   state_nx = {state[HALF-1:0], wbyte};
      ev_single: state_nx = lfsr_advance(state, 1, POLY);
      ev_rand:   state_nx = lfsr_advance(state, RAND_STEPS, POLY);
      default:   state_nx = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= state_nx;
  end

  // R9: the update sources are mutually exclusive
  p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_crc, ev_seed, ev_single, ev_rand}))
    else $error("more than one update event");

  // R7: off mode freezes the register
  p_off_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |=> $stable(state))
    else $error("register changed while off");

  // R3: seeding shifts the low byte up
  p_seed_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_wr && !crc_wr && mode != MODE_OFF) |=>
      (state[LFSR_W-1:BYTE_W] == $past(state[HALF-1:0])) && (state[BYTE_W-1:0] == $past(wbyte)))
    else $error("seed write did not shift");

  // R8: manual mode ignores low reads
  p_manual_no_read_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MANUAL && !crc_wr && !seed_wr) |=> $stable(state))
    else $error("manual mode register moved without a write");

  // R9: a CRC write beats a read step in the same cycle
  p_crc_beats_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_wr && low_rd && mode == MODE_RAND) |=> (state == crc_byte($past(state), $past(wbyte), POLY)))
    else $error("read step overrode CRC write");
endmodule

// File: rtl/lfsr_readback.sv
module lfsr_readback
  import lfsr_crc_pkg::*;
(
  input  logic [1:0]        rd_addr,
  input  logic [LFSR_W-1:0] state,
  input  mode_e             mode,
  output logic [BYTE_W-1:0] rd_data
);
  always_comb begin
    unique case (addr_e'(rd_addr))
      ADR_LOW:  rd_data = state[BYTE_W-1:0];
      ADR_HIGH: rd_data = state[LFSR_W-1:LFSR_W-BYTE_W];
      ADR_MODE: rd_data = {{(BYTE_W-MODE_W){1'b0}}, mode};
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/lfsr_crc_engine.sv
module lfsr_crc_engine
  import lfsr_crc_pkg::*;
#(
  parameter logic [LFSR_W-1:0] POLY       = 16'h8005,
  parameter int unsigned       RAND_STEPS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  logic              crc_wr, seed_wr, mode_wr, low_rd;
  mode_e             mode;
  logic [LFSR_W-1:0] state;

  lfsr_bus_decode u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .crc_wr  (crc_wr),
    .seed_wr (seed_wr),
    .mode_wr (mode_wr),
    .low_rd  (low_rd)
  );

  lfsr_mode_reg u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (mode_wr),
    .mode_wval (wr_data[MODE_W-1:0]),
    .mode      (mode)
  );

  lfsr_state #(.POLY(POLY), .RAND_STEPS(RAND_STEPS)) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .crc_wr  (crc_wr),
    .seed_wr (seed_wr),
    .low_rd  (low_rd),
    .wbyte   (wr_data),
    .state   (state)
  );

  lfsr_readback u_rb (
    .rd_addr (rd_addr),
    .state   (state),
    .mode    (mode),
    .rd_data (rd_data)
  );

  // R1: leaving reset the register and mode are clear
  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (state == '0 && mode == MODE_RAND))
    else $error("reset state wrong");
endmodule

// File: tb/lfsr_crc_engine_test.sv
module lfsr_crc_engine_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = 2'd3;
  logic [7:0] rd_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] m_s;
  logic [1:0]  m_mode;
  logic [7:0]  last_rd;

  always #(CLK_P/2) clk = ~clk;

  lfsr_crc_engine uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Byte-wise polynomial division form, independent of the bit-serial RTL view.
  function automatic logic [15:0] ref_crc(input logic [15:0] s, input logic [7:0] b);
    int v;
    v = int'(s) ^ (int'(b) << 8);
    for (int k = 0; k < 8; k++) begin
      if (v & 32'h8000) v = ((v << 1) ^ 32'h8005) & 32'hFFFF;
      else              v = (v << 1) & 32'hFFFF;
    end
    return v[15:0];
  endfunction

  function automatic logic [15:0] ref_rand(input logic [15:0] s, input int n);
    int v;
    v = int'(s);
    for (int k = 0; k < n; k++) begin
      if (v & 32'h8000) v = ((v << 1) ^ 32'h8005) & 32'hFFFF;
      else              v = (v << 1) & 32'hFFFF;
    end
    return v[15:0];
  endfunction

  function automatic logic [7:0] ref_read(input logic [1:0] a);
    case (a)
      2'd0: return m_s[7:0];
      2'd1: return m_s[15:8];
      2'd2: return {6'd0, m_mode};
      default: return 8'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus cycle: drive after negedge, compare rd_data before posedge, then step the model.
  task automatic cyc(input bit we, input logic [1:0] wa, input logic [7:0] wd,
                     input bit re, input logic [1:0] ra);
    logic [15:0] ns;
    logic [1:0]  nm;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    #1;
    last_rd = rd_data;
    chk("R2 readback", {8'd0, rd_data}, {8'd0, ref_read(ra)});
    @(posedge clk);
    ns = m_s;
    if (m_mode == 2'b11)                 ns = m_s;
    else if (we && wa == 2'd1)           ns = ref_crc(m_s, wd);
    else if (we && wa == 2'd0)           ns = {m_s[7:0], wd};
    else if (m_mode == 2'b01)            ns = ref_rand(m_s, 1);
    else if (m_mode == 2'b00 && re && ra == 2'd0) ns = ref_rand(m_s, 13);
    nm = m_mode;
    if (we && wa == 2'd2)  nm = wd[1:0];
    else if (m_mode == 2'b01) nm = 2'b00;
    m_s = ns;
    m_mode = nm;
  endtask

  task automatic idle(); cyc(0, 2'd0, 8'd0, 0, 2'd3); endtask

  task automatic peek(output logic [15:0] v);
    logic [7:0] lo;
    cyc(0, 2'd0, 8'd0, 0, 2'd0); lo = last_rd;
    cyc(0, 2'd0, 8'd0, 0, 2'd1); v = {last_rd, lo};
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    m_s = 16'h0000; m_mode = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    cyc(0, 2'd0, 8'd0, 0, 2'd2);
    chk("R1 mode after reset", {8'd0, last_rd}, 16'h0000);
    peek(v);
    chk("R1 register after reset", v, 16'h0000);
    // address 3 reads zero (R2)
    cyc(0, 2'd0, 8'd0, 0, 2'd3);
    chk("R2 unused address", {8'd0, last_rd}, 16'h0000);

    // R3 seeding, R4 CRC vector back to back
    cyc(1, 2'd0, 8'hFF, 0, 2'd3);
    cyc(1, 2'd0, 8'hFF, 0, 2'd3);
    peek(v);
    chk("R3 seed FFFF", v, 16'hFFFF);
    cyc(1, 2'd1, 8'h03, 0, 2'd3);
    cyc(1, 2'd1, 8'h41, 0, 2'd3);
    cyc(1, 2'd1, 8'h42, 0, 2'd3);
    cyc(1, 2'd1, 8'h43, 0, 2'd3);
    peek(v);
    chk("R4 CRC vector", v, 16'hB4BC);

    // R3 ordering of seed bytes
    cyc(1, 2'd0, 8'h12, 0, 2'd3);
    cyc(1, 2'd0, 8'h34, 0, 2'd3);
    peek(v);
    chk("R3 seed order", v, 16'h1234);

    // R5 read steps, each read shows pre-update byte (R2)
    cyc(0, 2'd0, 8'd0, 1, 2'd0);
    chk("R2 pre-update low byte", {8'd0, last_rd}, 16'h0034);
    peek(v);
    chk("R5 13-step read", v, ref_rand(16'h1234, 13));
    for (int k = 0; k < 6; k++) cyc(0, 2'd0, 8'd0, 1, 2'd0);

    // R6 single step
    cyc(1, 2'd0, 8'hA5, 0, 2'd3);
    cyc(1, 2'd0, 8'h5A, 0, 2'd3);
    cyc(1, 2'd2, 8'h01, 0, 2'd3);
    cyc(0, 2'd0, 8'd0, 0, 2'd2);
    chk("R6 mode pending", {8'd0, last_rd}, 16'h0001);
    cyc(0, 2'd0, 8'd0, 0, 2'd2);
    chk("R6 mode self-cleared", {8'd0, last_rd}, 16'h0000);
    peek(v);
    chk("R6 one step", v, ref_rand(16'hA55A, 1));

    // R7 off mode ignores everything but mode writes
    cyc(1, 2'd2, 8'h03, 0, 2'd3);
    cyc(1, 2'd0, 8'h77, 0, 2'd3);
    cyc(1, 2'd1, 8'h88, 1, 2'd0);
    cyc(0, 2'd0, 8'd0, 1, 2'd0);
    peek(v);
    chk("R7 held while off", v, ref_rand(16'hA55A, 1));

    // R8 manual mode: reads do not step, writes do
    cyc(1, 2'd2, 8'h02, 0, 2'd3);
    cyc(0, 2'd0, 8'd0, 1, 2'd0);
    cyc(0, 2'd0, 8'd0, 1, 2'd0);
    peek(v);
    chk("R8 reads ignored", v, ref_rand(16'hA55A, 1));
    cyc(1, 2'd0, 8'hC3, 0, 2'd3);
    peek(v);
    chk("R8 seed still works", v, {ref_rand(16'hA55A, 1) & 16'h00FF, 8'hC3} >> 0 == 16'h0 ? 16'h0 : {ref_rand(16'hA55A,1)[7:0], 8'hC3});

    // R9 CRC write beats read step in mode 00
    cyc(1, 2'd2, 8'h00, 0, 2'd3);
    cyc(1, 2'd0, 8'hFF, 0, 2'd3);
    cyc(1, 2'd0, 8'hFF, 0, 2'd3);
    cyc(1, 2'd1, 8'h03, 1, 2'd0);
    peek(v);
    chk("R9 write beats read", v, ref_crc(16'hFFFF, 8'h03));
    // R9 data write cancels pending single step
    cyc(1, 2'd2, 8'h01, 0, 2'd3);
    cyc(1, 2'd0, 8'h66, 0, 2'd3);
    peek(v);
    chk("R9 step cancelled", v, {ref_crc(16'hFFFF, 8'h03)[7:0], 8'h66});
    cyc(0, 2'd0, 8'd0, 0, 2'd2);
    chk("R9 mode cleared", {8'd0, last_rd}, 16'h0000);

    // Mixed traffic, compared every cycle against the model
    for (int k = 0; k < 600; k++) begin
      logic [1:0] wa;
      logic [1:0] ra;
      bit we, re;
      logic [7:0] wd;
      we = ($urandom_range(0, 2) == 0);
      wa = 2'($urandom_range(0, 3));
      wd = 8'($urandom_range(0, 255));
      if (we && wa == 2'd2 && wd[1:0] == 2'b11 && $urandom_range(0, 1) == 1) wd[1:0] = 2'b00;
      re = ($urandom_range(0, 1) == 1);
      ra = 2'($urandom_range(0, 3));
      cyc(we, wa, wd, re, ra);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule